// File: doc/BRIEF.md
# Bit-Stream Packet Encapsulator

This block turns a continuous bit-stream into a run of fixed-size packets for transport over a packet network. The stream arrives as parallel words with a valid strobe. The bits are packed into payloads strictly in arrival order, most significant bit first, and no framing inside the stream is examined. Each packet leaves the block as a byte-wide stream with start and end markers. It carries a 4-byte control word, then a 12-byte RTP-style header, then the payload.

The control word has a leading zero nibble, which tells a receiver that this is a control word and not a channel header. After that come a local-fault flag, a remote-defect flag and a 16-bit packet counter. The RTP-style header carries a version of 2, a configured payload type, a second 16-bit sequence counter, a timestamp and a configured source identifier. The timestamp is taken from a free-running counter of reference ticks.

Raising `en` latches the payload size, payload type, source identifier and initial RTP sequence value. They then stay fixed until the block is disabled and enabled again. A packet starts only when a whole payload is buffered, so a stall in the input holds the output back and a partial packet is never sent.

Top module: `ple_encap`

## Requirements
- R1: A packet is 16 header bytes followed by the payload bytes, sent one byte per cycle with no gap. `out_sop` is high on the first byte only and `out_eop` on the last byte only.
- R2: Header byte 0 is {4'b0000, L, R, 2'b00}, where L is `ac_fault` and R is `rx_defect`, both sampled when the packet starts. Header byte 1 is 0x00.
- R3: Header byte 4 is 0x80 (version 2, no padding, no extension, no CSRC). Byte 5 is {0, payload type}. Bytes 12..15 are the source identifier, most significant byte first.
- R4: Bytes 2..3 hold the control-word counter, most significant byte first. It is 0 for the first packet after enable and rises by 1 per packet, modulo 2^16.
- R5: Bytes 6..7 hold the RTP sequence number. It starts at the value latched at enable and rises by 1 per packet, modulo 2^16.
- R6: Bytes 8..11 hold the count of cycles with `ts_tick` high since reset, sampled when the packet starts. Toggling `en` does not clear this count.
- R7: The payload bytes are the input words in arrival order, with each word split from its most significant byte down.
- R8: A packet starts only once all of its payload words have been received. A stall inside a payload keeps the output idle.
- R9: The payload size, payload type, source identifier and initial sequence value are captured in the first cycle that `en` is high. Changes while enabled have no effect.
- R10: While `en` is low, input words are discarded, the buffer is emptied and no bytes are sent.
- R11: After reset, all outputs are 0.
- R12: The payload size may be any multiple of `IN_BYTES` from `IN_BYTES` up to `MAX_PAY_BYTES`. The default maximum of 1024 bytes is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Connection up; its rising edge latches the configuration |
| cfg_pay_bytes | input | $clog2(MAX_PAY_BYTES+1) | Payload size in bytes |
| cfg_pt | input | 7 | RTP payload type |
| cfg_ssrc | input | 32 | RTP source identifier |
| cfg_seq_init | input | 16 | First RTP sequence number |
| ac_fault | input | 1 | Local attachment fault, copied to the L flag |
| rx_defect | input | 1 | Receive-side loss or degrade defect, copied to the R flag |
| ts_tick | input | 1 | Reference clock tick for the timestamp counter |
| in_valid | input | 1 | Input word strobe |
| in_data | input | 8*IN_BYTES | Input word, earliest bit in the MSB |
| out_valid | output | 1 | Output byte valid |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_data | output | 8 | Output byte |

## Verification
The assertions take the following for granted about the inputs:
- The input never delivers words faster than packets drain, so the buffer never holds more than two payloads.
- The configured size is a legal multiple of the word width.
- The no-gap property is checked only while `en` stays high.

The stimulus respects these assumptions. It sweeps every legal payload size of a small configuration and re-enables the block for each size. It feeds one payload at a time and waits for that packet to finish, stalls the first payload of each size just short of its last word, and scrambles the configuration inputs right after each enable.

// File: rtl/ple_pkg.sv
package ple_pkg;

  localparam int HDR_BYTES = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY
  } ple_state_e;

  typedef struct packed {
    logic        lf;
    logic        rdi;
    logic [15:0] cw_seq;
    logic [6:0]  pt;
    logic [15:0] rtp_seq;
    logic [31:0] ts;
    logic [31:0] ssrc;
  } ple_hdr_t;

endpackage

// File: rtl/ple_word_fifo.sv
module ple_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 512
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_wr, do_rd;

  assign do_wr = wr_en && !flush;
  assign do_rd = rd_en && !flush;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    do_wr && !do_rd |-> count < CW'(DEPTH));

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    do_rd |-> count != '0);

endmodule

// File: rtl/ple_tick_ctr.sv
module ple_tick_ctr #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [TS_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (tick) value <= value + 1'b1;
  end
endmodule

// File: rtl/ple_hdr_mux.sv
module ple_hdr_mux
  import ple_pkg::*;
(
  input  ple_hdr_t    hdr,
  input  logic [3:0]  idx,
  output logic [7:0]  byte_o
);
  logic [8*HDR_BYTES-1:0] flat;

  always_comb begin
    flat = {4'h0, hdr.lf, hdr.rdi, 2'b00, 8'h00, hdr.cw_seq,
            2'b10, 6'b000000, 1'b0, hdr.pt, hdr.rtp_seq, hdr.ts, hdr.ssrc};
    byte_o = flat[(HDR_BYTES-1-int'(idx))*8 +: 8];
  end
endmodule

// File: rtl/ple_encap.sv
module ple_encap
  import ple_pkg::*;
#(
  parameter int IN_BYTES      = 4,
  parameter int MAX_PAY_BYTES = 1024
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               en,
  input  logic [$clog2(MAX_PAY_BYTES+1)-1:0] cfg_pay_bytes,
  input  logic [6:0]                         cfg_pt,
  input  logic [31:0]                        cfg_ssrc,
  input  logic [15:0]                        cfg_seq_init,
  input  logic                               ac_fault,
  input  logic                               rx_defect,
  input  logic                               ts_tick,
  input  logic                               in_valid,
  input  logic [8*IN_BYTES-1:0]              in_data,
  output logic                               out_valid,
  output logic                               out_sop,
  output logic                               out_eop,
  output logic [7:0]                         out_data
);
  localparam int IN_W      = 8 * IN_BYTES;
  localparam int MAX_WORDS = MAX_PAY_BYTES / IN_BYTES;
  localparam int DEPTH     = 2 * MAX_WORDS;
  localparam int PAY_W     = $clog2(MAX_PAY_BYTES + 1);
  localparam int CNT_W     = $clog2(DEPTH + 1);
  localparam int SH        = $clog2(IN_BYTES);
  localparam int BS_W      = (IN_BYTES > 1) ? $clog2(IN_BYTES) : 1;
  localparam logic [BS_W-1:0] LAST_B = BS_W'(IN_BYTES - 1);

  ple_state_e        state;
  logic              active;
  logic [PAY_W-1:0]  plen_words;
  logic [PAY_W-1:0]  wleft;
  logic [6:0]        pt_q;
  logic [31:0]       ssrc_q;
  logic [15:0]       cw_seq, rtp_seq;
  logic [3:0]        hidx;
  logic [BS_W-1:0]   bsel;
  ple_hdr_t          hdr_q;

  logic [IN_W-1:0]   rd_data;
  logic [CNT_W-1:0]  fcnt;
  logic              rd_en;
  logic              enough;
  logic [31:0]       ts_now;
  logic [7:0]        hdr_byte;
  logic [7:0]        pay_byte;

  ple_word_fifo #(.W(IN_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (!en),
    .wr_en   (en && in_valid),
    .wr_data (in_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .count   (fcnt)
  );

  ple_tick_ctr #(.TS_W(32)) u_ts (
    .clk   (clk),
    .rst   (rst),
    .tick  (ts_tick),
    .value (ts_now)
  );

  ple_hdr_mux u_hdr (
    .hdr    (hdr_q),
    .idx    (hidx),
    .byte_o (hdr_byte)
  );

  always_comb begin
    enough   = active && (32'(fcnt) >= 32'(plen_words));
    rd_en    = en && (((state == ST_HDR) && (hidx == 4'd15)) ||
                      ((state == ST_PAY) && (bsel == LAST_B) && (wleft > PAY_W'(1))));
    pay_byte = rd_data[(IN_BYTES-1-int'(bsel))*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      active     <= 1'b0;
      plen_words <= '0;
      wleft      <= '0;
      pt_q       <= '0;
      ssrc_q     <= '0;
      cw_seq     <= '0;
      rtp_seq    <= '0;
      hidx       <= '0;
      bsel       <= '0;
      hdr_q      <= '0;
      out_valid  <= 1'b0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_data   <= '0;
    end else begin
      active    <= en;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_data  <= '0;
      if (en && !active) begin
        plen_words <= PAY_W'(cfg_pay_bytes >> SH);
        pt_q       <= cfg_pt;
        ssrc_q     <= cfg_ssrc;
        cw_seq     <= '0;
        rtp_seq    <= cfg_seq_init;
      end
      if (!en) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (enough) begin
              hdr_q.lf      <= ac_fault;
              hdr_q.rdi     <= rx_defect;
              hdr_q.cw_seq  <= cw_seq;
              hdr_q.pt      <= pt_q;
              hdr_q.rtp_seq <= rtp_seq;
              hdr_q.ts      <= ts_now;
              hdr_q.ssrc    <= ssrc_q;
              cw_seq        <= cw_seq + 16'd1;
              rtp_seq       <= rtp_seq + 16'd1;
              hidx          <= '0;
              state         <= ST_HDR;
            end
          end
          ST_HDR: begin
            out_valid <= 1'b1;
            out_sop   <= (hidx == 4'd0);
            out_data  <= hdr_byte;
            hidx      <= hidx + 4'd1;
            if (hidx == 4'd15) begin
              bsel  <= '0;
              wleft <= plen_words;
              state <= ST_PAY;
            end
          end
          ST_PAY: begin
            out_valid <= 1'b1;
            out_data  <= pay_byte;
            if (bsel == LAST_B) begin
              bsel  <= '0;
              wleft <= wleft - PAY_W'(1);
              if (wleft == PAY_W'(1)) begin
                out_eop <= 1'b1;
                state   <= ST_IDLE;
              end
            end else begin
              bsel <= bsel + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1
  sop_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_valid && !out_eop);

  // R1
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_eop && en |=> out_valid);

  // R2
  cw_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    out_sop |-> out_data[7:4] == 4'h0);

  // R8
  full_payload_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR) && (hidx == 4'd0) |-> 32'(fcnt) >= 32'(plen_words));

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !out_valid);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    active && $past(active) |-> $stable(plen_words) && $stable(ssrc_q));

endmodule

// File: tb/test_ple_encap.sv
module test_ple_encap;
  localparam int IB = 2;
  localparam int MP = 32;
  localparam int PW = $clog2(MP + 1);

  logic          clk, rst, en;
  logic [PW-1:0] cfg_pay_bytes;
  logic [6:0]    cfg_pt;
  logic [31:0]   cfg_ssrc;
  logic [15:0]   cfg_seq_init;
  logic          ac_fault, rx_defect, ts_tick, in_valid;
  logic [8*IB-1:0] in_data;
  logic          out_valid, out_sop, out_eop;
  logic [7:0]    out_data;

  ple_encap #(.IN_BYTES(IB), .MAX_PAY_BYTES(MP)) i_ple_encap (
    .clk(clk), .rst(rst), .en(en), .cfg_pay_bytes(cfg_pay_bytes),
    .cfg_pt(cfg_pt), .cfg_ssrc(cfg_ssrc), .cfg_seq_init(cfg_seq_init),
    .ac_fault(ac_fault), .rx_defect(rx_defect), .ts_tick(ts_tick),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int unsigned ticks = 0;

  logic [7:0] cap[$];
  int sop_pos[$];
  int eop_pos[$];
  int gap_err = 0;
  int sop_err = 0;
  bit prev_valid = 0;
  bit in_pkt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (out_sop) begin
          if (in_pkt) sop_err++;
          sop_pos.push_back(cap.size());
          in_pkt = 1;
        end else if (!prev_valid) gap_err++;
        cap.push_back(out_data);
        if (out_eop) begin
          eop_pos.push_back(cap.size() - 1);
          in_pkt = 0;
        end
      end else if (in_pkt) gap_err++;
      prev_valid = out_valid;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ts_tick = 1'b1;
      @(negedge clk) ts_tick = 1'b0;
      ticks++;
    end
  endtask

  task automatic push(logic [8*IB-1:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [15:0] word_val(int pk, int k);
    return 16'((pk * 73 + k * 29 + 16'h1357) ^ (k << 9));
  endfunction

  task automatic check_pkt(int n, int p, int j, bit l, bit r, logic [6:0] pt,
                           logic [31:0] ssrc, logic [15:0] seq0, int unsigned ts);
    int o;
    int errs;
    o = sop_pos[n];
    chk("R1", "sop/eop pairing", longint'(eop_pos.size()), longint'(sop_pos.size()));
    chk("R12", "packet length", longint'(eop_pos[n] - o + 1), longint'(16 + p));
    chk("R2", "control byte0", cap[o], {4'b0000, l, r, 2'b00});
    chk("R2", "control byte1", cap[o+1], 8'h00);
    chk("R4", "control seq", {cap[o+2], cap[o+3]}, longint'(j));
    chk("R3", "rtp version byte", cap[o+4], 8'h80);
    chk("R3", "rtp payload type", cap[o+5], {1'b0, pt});
    chk("R3", "rtp ssrc", {cap[o+12], cap[o+13], cap[o+14], cap[o+15]}, ssrc);
    chk("R5", "rtp seq", {cap[o+6], cap[o+7]}, 16'(seq0 + 16'(j)));
    chk("R6", "timestamp", {cap[o+8], cap[o+9], cap[o+10], cap[o+11]}, longint'(ts));
    errs = 0;
    for (int k = 0; k < p / IB; k++) begin
      logic [15:0] w;
      w = word_val(n, k);
      if (cap[o+16+2*k] != w[15:8]) errs++;
      if (cap[o+17+2*k] != w[7:0]) errs++;
    end
    chk("R7", "payload byte mismatches", errs, 0);
  endtask

  initial begin
    int gpk;
    rst = 1'b1; en = 1'b0; cfg_pay_bytes = '0; cfg_pt = '0; cfg_ssrc = '0;
    cfg_seq_init = '0; ac_fault = 1'b0; rx_defect = 1'b0; ts_tick = 1'b0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11", "out_valid", out_valid, 0);
    chk("R11", "out_sop", out_sop, 0);
    chk("R11", "out_eop", out_eop, 0);
    chk("R11", "out_data", out_data, 0);

    // R10 input discarded while disabled
    cfg_pay_bytes = PW'(IB);
    for (int k = 0; k < 6; k++) push(16'hF0F0 + 16'(k));
    repeat (20) @(negedge clk);
    chk("R10", "bytes sent while disabled", cap.size(), 0);

    gpk = 0;
    for (int p = IB; p <= MP; p += IB) begin
      logic [6:0]  pt;
      logic [31:0] ssrc;
      logic [15:0] seq0;
      en = 1'b0;
      repeat (2) @(negedge clk);
      pt   = 7'(p * 5 + 1);
      ssrc = 32'hA5C30000 + 32'(p);
      seq0 = 16'(16'hFFFC + 16'(p / IB));
      cfg_pay_bytes = PW'(p);
      cfg_pt = pt;
      cfg_ssrc = ssrc;
      cfg_seq_init = seq0;
      tick_n(p % 5 + 1);
      @(negedge clk) en = 1'b1;
      // R9 scramble configuration right after enable
      @(negedge clk);
      cfg_pay_bytes = PW'((p == IB) ? 2 * IB : IB);
      cfg_pt = 7'h00;
      cfg_ssrc = 32'h0;
      cfg_seq_init = 16'h1234;
      for (int j = 0; j < 3; j++) begin
        bit l, r;
        int unsigned ets;
        l = j[0];
        r = (j == 1) || (p % 4 == 0);
        ac_fault = l;
        rx_defect = r;
        for (int k = 0; k < p / IB - 1; k++) push(word_val(gpk, k));
        if (j == 0) begin
          repeat (25) @(negedge clk);
          // R8 stalled payload must not start a packet
          chk("R8", "packets before full payload", sop_pos.size(), gpk);
        end
        ets = ticks;
        push(word_val(gpk, p / IB - 1));
        while (eop_pos.size() <= gpk) @(negedge clk);
        check_pkt(gpk, p, j, l, r, pt, ssrc, seq0, ets);
        gpk++;
        tick_n(j + 2);
      end
    end
    repeat (5) @(negedge clk);
    chk("R1", "gaps inside packets", gap_err, 0);
    chk("R1", "nested sop", sop_err, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule